// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Staged Host Access

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, date, month, year, day of week and a century byte. It advances by one second on each cycle in which the one-second tick input is high. It handles 12-hour and 24-hour display, month lengths and February 29. Hours, days, months, years and the century carry into one another in the usual way.

A bus front end drives a set of strobes. A snapshot strobe freezes a copy of all eight bytes for reading, so a multi-byte read stays consistent while the counters keep running. A write session opens with a strobe that copies the live time into a shadow buffer. Byte writes then patch single buffer entries. A commit strobe, issued on a valid stop, copies the whole buffer into the counters. An abort strobe drops the buffer. A power-fail flag is set by reset, which stands for total power loss. While the flag is set the clock stays still, and the first commit that carries a written byte clears it.

Field index map used by both read and write ports: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week, 7 century.

Top module: `cal_keeper`

## Requirements
- R1: After reset, fail_o is 1 and the snapshot reads 00 seconds, 00 minutes, hour byte 0x80 (24-hour mode, hour 00), date 0x01, month 0x01, year 0x00, day of week 0, century 0x20.
- R2: Seconds and minutes count 0x00 to 0x59 in BCD. On 0x59 they wrap to 0x00 and carry into the next field.
- R3: Hour byte: bit 7 set selects 24-hour mode, with bits 5:0 holding 0x00 to 0x23, and 23 wraps to 00 with a day carry. Bit 7 clear selects 12-hour mode, with bits 4:0 holding 0x01 to 0x12 and bit 5 set for PM. In 12-hour mode 11 goes to 12 and toggles bit 5, 12 goes to 01, and only 11 PM to 12 AM carries a day.
- R4: On a day carry the date advances, and after the last day of the month (30 for months 0x04, 0x06, 0x09, 0x11; 31 otherwise except February) it returns to 0x01 and the month advances. The month wraps 0x12 to 0x01 into the year. The day of week (stored in bits 2:0, upper bits zero) counts 0 to 6 and wraps to 0.
- R5: February ends on 0x29 when the year value is divisible by 4, year 00 included, and on 0x28 otherwise.
- R6: A year wrap from 0x99 to 0x00 sets the century to 0x20. The century only ever holds 0x19 or 0x20, and a written century other than 0x19 is stored as 0x20.
- R7: While fail_o is 1, ticks do not move the time. A commit carrying at least one written byte clears fail_o and the clock runs from then on.
- R8: A snapshot strobe copies all eight bytes into the read latch. rd_data_o shows latch byte rd_idx_i, and later ticks do not alter it until the next snapshot.
- R9: Opening a session loads the buffer with the live time. Byte writes replace buffer entries while the counters keep ticking. A commit copies the buffer into the counters, and an abort leaves the counters running untouched.
- R10: When a commit and a tick fall in the same cycle, the committed value is loaded without advancing. The first advance happens on the next tick.
- R11: Fields not written in a session take the buffer values captured when it opened, even if the clock ran on meanwhile.
- R12: Byte writes and commits outside an open session are ignored, and a commit with no written byte leaves time and fail_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, marks total power loss |
| tick_i | input | 1 | One-second advance request, one cycle per second |
| snap_i | input | 1 | Snapshot strobe: freeze time into the read latch |
| wr_open_i | input | 1 | Open a write session, load buffer from live time |
| wr_en_i | input | 1 | Byte write into the buffer |
| wr_idx_i | input | 3 | Field index for the byte write |
| wr_data_i | input | 8 | BCD byte to write |
| commit_i | input | 1 | Valid stop: copy buffer into the counters |
| abort_i | input | 1 | Invalid end: discard buffer |
| rd_idx_i | input | 3 | Field index for reading the latch |
| rd_data_o | output | 8 | Selected latch byte |
| fail_o | output | 1 | Power-fail flag, clock halted while set |

## Verification
On every cycle, the assertions check that the counters stand still while the fail flag holds or when neither a tick nor a commit arrives. They also check that the century stays at 19 or 20, that the read latch changes only on a snapshot, and that the buffer changes only on an open or an accepted byte write. The exact roll-over values need the bench's scenarios: 12-hour noon and midnight, month ends, February in leap and common years, century roll, single-byte patches, aborted sessions and a commit that meets a tick. The bench checks these against a binary reference model over directed corners and random start times.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned FIELD_W  = 8;
  localparam int unsigned N_FIELDS = 8;
  localparam int unsigned IDX_W    = $clog2(N_FIELDS);

  localparam int unsigned F_SEC = 0;
  localparam int unsigned F_MIN = 1;
  localparam int unsigned F_HR  = 2;
  localparam int unsigned F_DT  = 3;
  localparam int unsigned F_MO  = 4;
  localparam int unsigned F_YR  = 5;
  localparam int unsigned F_DW  = 6;
  localparam int unsigned F_CEN = 7;

  typedef logic [N_FIELDS-1:0][FIELD_W-1:0] cal_vec_t;

  function automatic logic [FIELD_W-1:0] bcd_inc(input logic [FIELD_W-1:0] v);
    if (v[3:0] == 4'd9) bcd_inc = {v[7:4] + 4'd1, 4'd0};
    else                bcd_inc = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [FIELD_W-1:0] month_last(input logic [FIELD_W-1:0] mo,
                                                    input logic [FIELD_W-1:0] yr);
    logic leap;
    leap = (!yr[4] && (yr[3:0] == 4'd0 || yr[3:0] == 4'd4 || yr[3:0] == 4'd8)) ||
           ( yr[4] && (yr[3:0] == 4'd2 || yr[3:0] == 4'd6));
    case (mo)
      8'h02:                      month_last = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: month_last = 8'h30;
      default:                    month_last = 8'h31;
    endcase
  endfunction

  function automatic cal_vec_t time_at_reset();
    cal_vec_t t;
    t        = '0;
    t[F_HR]  = 8'h80;
    t[F_DT]  = 8'h01;
    t[F_MO]  = 8'h01;
    t[F_CEN] = 8'h20;
    return t;
  endfunction
endpackage

// File: rtl/cal_advance.sv
module cal_advance
  import cal_pkg::*;
(
  input  cal_vec_t cur_i,
  output cal_vec_t nxt_o
);
  logic [FIELD_W-1:0] hr, hr_n, hr_inc, last_day;
  logic sec_wrap, min_wrap, day_c, dt_wrap, mo_wrap, yr_wrap;

  always_comb begin
    hr       = cur_i[F_HR];
    hr_n     = hr;
    hr_inc   = '0;
    day_c    = 1'b0;
    if (hr[7]) begin
      if (hr[5:0] == 6'h23) begin
        hr_n  = 8'h80;
        day_c = 1'b1;
      end else begin
        hr_inc = bcd_inc({2'b00, hr[5:0]});
        hr_n   = {2'b10, hr_inc[5:0]};
      end
    end else begin
      if (hr[4:0] == 5'h11) begin
        hr_n  = {2'b00, ~hr[5], 5'h12};
        day_c = hr[5];
      end else if (hr[4:0] == 5'h12) begin
        hr_n  = {2'b00, hr[5], 5'h01};
      end else begin
        hr_inc = bcd_inc({3'b000, hr[4:0]});
        hr_n   = {2'b00, hr[5], hr_inc[4:0]};
      end
    end
  end

  always_comb begin
    nxt_o    = cur_i;
    last_day = month_last(cur_i[F_MO], cur_i[F_YR]);
    sec_wrap = (cur_i[F_SEC] == 8'h59);
    min_wrap = (cur_i[F_MIN] == 8'h59);
    dt_wrap  = (cur_i[F_DT] == last_day);
    mo_wrap  = (cur_i[F_MO] == 8'h12);
    yr_wrap  = (cur_i[F_YR] == 8'h99);

    nxt_o[F_SEC] = sec_wrap ? 8'h00 : bcd_inc(cur_i[F_SEC]);
    if (sec_wrap) begin
      nxt_o[F_MIN] = min_wrap ? 8'h00 : bcd_inc(cur_i[F_MIN]);
      if (min_wrap) begin
        nxt_o[F_HR] = hr_n;
        if (day_c) begin
          nxt_o[F_DW] = (cur_i[F_DW][2:0] >= 3'd6) ? 8'h00 : {5'd0, cur_i[F_DW][2:0] + 3'd1};
          nxt_o[F_DT] = dt_wrap ? 8'h01 : bcd_inc(cur_i[F_DT]);
          if (dt_wrap) begin
            nxt_o[F_MO] = mo_wrap ? 8'h01 : bcd_inc(cur_i[F_MO]);
            if (mo_wrap) begin
              nxt_o[F_YR] = yr_wrap ? 8'h00 : bcd_inc(cur_i[F_YR]);
              if (yr_wrap) nxt_o[F_CEN] = 8'h20;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/cal_stage.sv
module cal_stage
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  cal_vec_t           time_i,
  input  logic               snap_i,
  input  logic               open_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic               commit_i,
  input  logic               abort_i,
  output cal_vec_t           buf_o,
  output cal_vec_t           snap_o,
  output logic               commit_go_o
);
  cal_vec_t buf_q, buf_d, snap_q, snap_d;
  logic open_q, open_d, dirty_q, dirty_d, wr_go;
  logic [FIELD_W-1:0] wr_val;

  assign wr_go       = wr_en_i && open_q && !open_i;
  assign commit_go_o = commit_i && open_q && dirty_q;

  always_comb begin
    case (wr_idx_i)
      IDX_W'(F_CEN): wr_val = (wr_data_i == 8'h19) ? 8'h19 : 8'h20;
      IDX_W'(F_DW):  wr_val = {5'd0, wr_data_i[2:0]};
      default:       wr_val = wr_data_i;
    endcase
  end

  always_comb begin
    buf_d   = buf_q;
    open_d  = open_q;
    dirty_d = dirty_q;
    snap_d  = snap_i ? time_i : snap_q;
    if (open_i) begin
      buf_d   = time_i;
      open_d  = 1'b1;
      dirty_d = 1'b0;
    end else if (open_q && (commit_i || abort_i)) begin
      open_d  = 1'b0;
      dirty_d = 1'b0;
    end else if (wr_go) begin
      buf_d[wr_idx_i] = wr_val;
      dirty_d         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q   <= time_at_reset();
      snap_q  <= time_at_reset();
      open_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      buf_q   <= buf_d;
      snap_q  <= snap_d;
      open_q  <= open_d;
      dirty_q <= dirty_d;
    end
  end

  assign buf_o  = buf_q;
  assign snap_o = snap_q;

  assert_snap_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_i |=> $stable(snap_q));
  assert_buf_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_i && !wr_go) |=> $stable(buf_q));
endmodule

// File: rtl/cal_keeper.sv
module cal_keeper
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               snap_i,
  input  logic               wr_open_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [FIELD_W-1:0] wr_data_i,
  input  logic               commit_i,
  input  logic               abort_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [FIELD_W-1:0] rd_data_o,
  output logic               fail_o
);
  cal_vec_t time_q, time_d, time_adv, buf_w, snap_w;
  logic fail_q, fail_d, commit_go, time_en;

  cal_advance u_adv (
    .cur_i (time_q),
    .nxt_o (time_adv)
  );

  cal_stage u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .time_i      (time_q),
    .snap_i      (snap_i),
    .open_i      (wr_open_i),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_data_i   (wr_data_i),
    .commit_i    (commit_i),
    .abort_i     (abort_i),
    .buf_o       (buf_w),
    .snap_o      (snap_w),
    .commit_go_o (commit_go)
  );

  assign time_en = commit_go || (tick_i && !fail_q);

  always_comb begin
    time_d = commit_go ? buf_w : time_adv;
    fail_d = commit_go ? 1'b0 : fail_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q <= time_at_reset();
      fail_q <= 1'b1;
    end else begin
      if (time_en) time_q <= time_d;
      fail_q <= fail_d;
    end
  end

  assign rd_data_o = snap_w[rd_idx_i];
  assign fail_o    = fail_q;

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !commit_go) |=> $stable(time_q));
  assert_fail_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !commit_go) |=> fail_q);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !commit_go) |=> $stable(time_q));
  assert_century_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (time_q[F_CEN] == 8'h19) || (time_q[F_CEN] == 8'h20));
endmodule

// File: tb/cal_keeper_bench.sv
module cal_keeper_bench;
  import cal_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, snap = 1'b0, wopen = 1'b0, wen = 1'b0, cmt = 1'b0, abrt = 1'b0;
  logic [2:0] widx = '0, ridx = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic fail;

  always #10 clk = ~clk;

  cal_keeper u_cal_keeper (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .snap_i(snap), .wr_open_i(wopen),
    .wr_en_i(wen), .wr_idx_i(widx), .wr_data_i(wdata), .commit_i(cmt),
    .abort_i(abrt), .rd_idx_i(ridx), .rd_data_o(rdata), .fail_o(fail)
  );

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  int m_sec, m_min, m_hr, m_dt, m_mo, m_yr, m_dw, m_ce;
  bit m_24, m_fail, dirty;
  logic [7:0] sb [8];
  logic [7:0] saved [8];

  function automatic logic [7:0] enc(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int dec(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int mlen(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] enc_hour(int h, bit f24);
    int h12;
    if (f24) return 8'h80 | enc(h);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return ((h >= 12) ? 8'h20 : 8'h00) | enc(h12);
  endfunction
  function automatic logic [7:0] exp_byte(int i);
    case (i)
      0: return enc(m_sec);
      1: return enc(m_min);
      2: return enc_hour(m_hr, m_24);
      3: return enc(m_dt);
      4: return enc(m_mo);
      5: return enc(m_yr);
      6: return 8'(m_dw);
      default: return enc(m_ce);
    endcase
  endfunction

  task automatic model_tick();
    if (m_fail) return;
    m_sec++;
    if (m_sec < 60) return;
    m_sec = 0; m_min++;
    if (m_min < 60) return;
    m_min = 0; m_hr++;
    if (m_hr < 24) return;
    m_hr = 0; m_dw = (m_dw + 1) % 7; m_dt++;
    if (m_dt <= mlen(m_mo, m_yr)) return;
    m_dt = 1; m_mo++;
    if (m_mo <= 12) return;
    m_mo = 1; m_yr++;
    if (m_yr <= 99) return;
    m_yr = 0; m_ce = 20;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic read_latch(string req, bit use_saved);
    for (int i = 0; i < 8; i++) begin
      ridx = 3'(i);
      #1;
      chk(req, rdata, use_saved ? saved[i] : exp_byte(i));
    end
  endtask

  task automatic check_time(string req);
    pulse(snap);
    read_latch(req, 1'b0);
  endtask

  task automatic ticks(int n);
    if (n <= 0) return;
    @(negedge clk); tick = 1'b1;
    repeat (n - 1) @(negedge clk);
    @(negedge clk); tick = 1'b0;
    repeat (n) model_tick();
  endtask

  task automatic open_w();
    pulse(wopen);
    for (int i = 0; i < 8; i++) sb[i] = exp_byte(i);
    dirty = 1'b0;
  endtask

  task automatic put(int i, logic [7:0] d);
    @(negedge clk); wen = 1'b1; widx = 3'(i); wdata = d;
    @(negedge clk); wen = 1'b0;
    if (i == 7) sb[i] = (d == 8'h19) ? 8'h19 : 8'h20;
    else if (i == 6) sb[i] = {5'd0, d[2:0]};
    else sb[i] = d;
    dirty = 1'b1;
  endtask

  task automatic model_commit();
    if (!dirty) return;
    m_sec = dec(sb[0]); m_min = dec(sb[1]);
    m_24  = sb[2][7];
    m_hr  = sb[2][7] ? dec({2'b00, sb[2][5:0]})
                     : (dec({3'b000, sb[2][4:0]}) % 12 + (sb[2][5] ? 12 : 0));
    m_dt = dec(sb[3]); m_mo = dec(sb[4]); m_yr = dec(sb[5]);
    m_dw = int'(sb[6][2:0]); m_ce = (sb[7] == 8'h19) ? 19 : 20;
    m_fail = 1'b0; dirty = 1'b0;
  endtask

  task automatic commit_w();
    pulse(cmt);
    model_commit();
  endtask

  task automatic set_time(int s, int mi, int h, bit f24, int dt, int mo, int yr, int dw, int ce);
    open_w();
    put(0, enc(s)); put(1, enc(mi)); put(2, enc_hour(h, f24)); put(3, enc(dt));
    put(4, enc(mo)); put(5, enc(yr)); put(6, 8'(dw)); put(7, enc(ce));
    commit_w();
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    m_sec = 0; m_min = 0; m_hr = 0; m_24 = 1; m_dt = 1; m_mo = 1; m_yr = 0;
    m_dw = 0; m_ce = 20; m_fail = 1; dirty = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 fail flag", 8'(fail), 8'd1);
    check_time("R1 reset time");

    // R7 ticks ignored while failed
    ticks(5);
    check_time("R7 frozen while failed");
    chk("R7 flag held", 8'(fail), 8'd1);

    // R12 writes and commit outside a session
    @(negedge clk); wen = 1'b1; widx = 3'd1; wdata = 8'h33;
    @(negedge clk); wen = 1'b0;
    pulse(cmt);
    check_time("R12 write outside session");
    chk("R12 fail untouched", 8'(fail), 8'd1);
    open_w();
    commit_w();
    chk("R12 empty commit keeps fail", 8'(fail), 8'd1);

    // R7 and R11 single byte commit starts clock
    open_w();
    put(0, 8'h30);
    commit_w();
    chk("R7 fail cleared", 8'(fail), 8'd0);
    check_time("R11 only seconds changed");
    ticks(1);
    check_time("R7 clock running");

    // R10 commit meeting a tick
    open_w();
    put(0, 8'h10);
    @(negedge clk); cmt = 1'b1; tick = 1'b1;
    @(negedge clk); cmt = 1'b0; tick = 1'b0;
    model_commit();
    check_time("R10 no advance on commit cycle");
    ticks(1);
    check_time("R10 first advance after commit");

    // R9 and R11 clock runs during session; unwritten fields from open time
    open_w();
    ticks(3);
    put(1, 8'h45);
    commit_w();
    check_time("R11 buffer values from open");

    // R9 abort
    open_w();
    put(1, 8'h07);
    pulse(abrt);
    dirty = 1'b0;
    ticks(2);
    check_time("R9 abort discards");

    // R8 snapshot frozen
    pulse(snap);
    for (int i = 0; i < 8; i++) saved[i] = exp_byte(i);
    ticks(7);
    read_latch("R8 latch frozen", 1'b1);
    check_time("R8 new snapshot");

    // R6 century roll and coercion
    set_time(59, 59, 23, 1, 31, 12, 99, 6, 19);
    ticks(1);
    check_time("R6 century 19 to 20");
    set_time(59, 59, 23, 1, 31, 12, 99, 2, 20);
    ticks(1);
    check_time("R6 century holds 20");
    open_w(); put(7, 8'h21); commit_w();
    check_time("R6 century coerced to 20");
    open_w(); put(7, 8'h19); commit_w();
    check_time("R6 century 19 stored");

    // R5 leap years
    set_time(59, 59, 23, 1, 28, 2, 24, 0, 20);
    ticks(1); check_time("R5 leap Feb 29");
    set_time(59, 59, 23, 1, 29, 2, 24, 0, 20);
    ticks(1); check_time("R5 leap to March");
    set_time(59, 59, 23, 1, 28, 2, 25, 0, 20);
    ticks(1); check_time("R5 common year to March");
    set_time(59, 59, 23, 1, 28, 2, 0, 0, 20);
    ticks(1); check_time("R5 year 00 is leap");

    // R4 month lengths
    set_time(59, 59, 23, 1, 30, 4, 10, 3, 20);
    ticks(1); check_time("R4 April 30");
    set_time(59, 59, 23, 1, 30, 9, 10, 4, 20);
    ticks(1); check_time("R4 Sept 30");
    set_time(59, 59, 23, 1, 30, 11, 10, 5, 20);
    ticks(1); check_time("R4 Nov 30");
    set_time(59, 59, 23, 1, 31, 1, 10, 5, 20);
    ticks(1); check_time("R4 Jan 31");
    set_time(59, 59, 23, 1, 30, 1, 10, 5, 20);
    ticks(1); check_time("R4 Jan 30 no wrap");

    // R3 12-hour behaviour
    set_time(59, 59, 23, 0, 15, 6, 30, 1, 20);
    ticks(1); check_time("R3 11PM to 12AM");
    set_time(59, 59, 11, 0, 15, 6, 30, 1, 20);
    ticks(1); check_time("R3 11AM to 12PM");
    set_time(59, 59, 12, 0, 15, 6, 30, 1, 20);
    ticks(1); check_time("R3 12PM to 1PM");
    set_time(59, 59, 0, 0, 15, 6, 30, 1, 20);
    ticks(1); check_time("R3 12AM to 1AM");
    set_time(59, 59, 9, 1, 15, 6, 30, 1, 20);
    ticks(1); check_time("R3 24h 09 to 10");

    // R2 second and minute carries
    set_time(59, 9, 0, 1, 15, 6, 30, 1, 20);
    ticks(61); check_time("R2 minute carry");

    // Random starts, R2 to R6
    for (int t = 0; t < 40; t++) begin
      int s, mi, h, mo, yr, dt;
      bit f24;
      s  = ($urandom % 3 == 0) ? 59 - int'($urandom % 3) : int'($urandom % 60);
      mi = ($urandom % 2 == 0) ? 59 : int'($urandom % 60);
      h  = ($urandom % 2 == 0) ? 23 : int'($urandom % 24);
      f24 = 1'($urandom % 2);
      mo = 1 + int'($urandom % 12);
      yr = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
      dt = ($urandom % 2 == 0) ? mlen(mo, yr) : 1 + int'($urandom % mlen(mo, yr));
      set_time(s, mi, h, f24, dt, mo, yr, int'($urandom % 7), 19 + int'($urandom % 2));
      ticks(1 + int'($urandom % 250));
      check_time("R2-R6 random run");
    end

    finish_run();
  end
endmodule